// File: doc/BRIEF.md
# Coherent Cyclic-Code Chip Despreader

This block turns a stream of signed soft chip samples into 16-ary symbol decisions. Each symbol starts with one guard chip, a cyclic extension that soaks up echoes of the previous symbol. The guard chip is followed by 8 or 16 payload chips. The block drops the guard chip, correlates the payload against all 16 candidate spreading codes at the same time, and reports the symbol with the largest correlation together with that correlation value.

All 16 candidates come from one root code per length. A candidate is the root, optionally with its odd-position chips inverted, then cyclically delayed. The block therefore derives each reference chip from the symbol index and the chip position, and holds no sequence table. Symbol timing comes from outside: a start pulse marks the guard chip of each symbol, and the code length is chosen for each symbol at that same strobe.

Top module: `cyc_despreader`

## Requirements
- R1: After reset, `sym_vld` is low and `sym_out` and `sym_peak` read 0.
- R2: In short mode (`len16`=0 at the start strobe) a chip bit 0 is sent as +A and a bit 1 as -A. The base code is the 8-bit root 0x5C, with chip 0 taken from the MSB. For symbol s, the odd-indexed chips of the base code are inverted when s[3]=1. The result is then cyclically delayed by s[2:0] chips, so that chip i takes base chip (i - shift) mod 8. Ideal chips for symbol s decode to `sym_out`=s with `sym_peak`=8A.
- R3: In long mode (`len16`=1) the same rule applies with the 16-bit root 0x2F53 and a delay of 2*s[2:0] chips, mod 16. Ideal chips decode to s with `sym_peak`=16A.
- R4: The chip strobed together with `sos` is the guard chip and never enters the correlation. Its value does not change `sym_out` or `sym_peak`.
- R5: `sym_vld` is high for exactly one cycle: the cycle after the cycle in which the last payload chip is strobed.
- R6: Cycles with `chip_vld` low are ignored. Chips strobed when no symbol is in progress are also ignored: they raise no `sym_vld` and leave `sym_out` and `sym_peak` unchanged.
- R7: When several symbols share the maximum correlation, the lowest symbol index is reported.
- R8: A `sos` strobe in the middle of a symbol discards the partial correlation and restarts on the new guard chip. Only the restarted symbol is reported.
- R9: Correlation is coherent on signed samples. `sym_peak` equals the sum over the payload of sample times reference sign for the reported symbol, and no other symbol has a larger sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chip_vld | input | 1 | Chip strobe; `chip_smp` is taken in this cycle |
| sos | input | 1 | With `chip_vld`: this chip is the guard chip of a new symbol |
| len16 | input | 1 | Code length for the symbol starting now: 0 for 8 chips, 1 for 16 chips |
| chip_smp | input | 8 | Signed soft chip sample |
| sym_vld | output | 1 | One-cycle decision strobe |
| sym_out | output | 4 | Decided symbol index |
| sym_peak | output | 13 | Signed correlation of the decided symbol |

## Verification
The bench targets four faults:
- A guard chip of extreme amplitude tests the drop. A design that correlated the guard chip would report a peak that differs from N*A.
- Gaps with garbage samples and stray chips after a finished symbol test the strobe handling. A design that counted them would shift the chip phase or raise a spurious strobe.
- A start pulse after a few chips of a long-mode symbol tests the restart. A design that kept the partial sums or the old length would report the wrong symbol, or report twice.
- An all-zero symbol tests tie-breaking toward index 0, and noisy symbols compared against an independent correlation test the signed arithmetic. A design with broken tie-breaking or unsigned arithmetic would report a different index or peak.

// File: rtl/cyc_despreader.sv
module cyc_despreader #(
  parameter int SMP_W = 8,
  parameter int NSYM = 16,
  parameter int MAXC = 16,
  parameter logic [7:0] ROOT_S = 8'h5C,
  parameter logic [15:0] ROOT_L = 16'h2F53
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  chip_vld,
  input  logic                                  sos,
  input  logic                                  len16,
  input  logic signed [SMP_W-1:0]               chip_smp,
  output logic                                  sym_vld,
  output logic [$clog2(NSYM)-1:0]               sym_out,
  output logic signed [SMP_W+$clog2(MAXC):0]    sym_peak
);
  localparam int IDX_W = $clog2(MAXC);
  localparam int SYM_W = $clog2(NSYM);
  localparam int ACC_W = SMP_W + IDX_W + 1;

  logic signed [ACC_W-1:0] acc [NSYM];
  logic [IDX_W-1:0] cnt;
  logic busy, long_q, done_q;

  wire start = chip_vld && sos;
  wire take  = chip_vld && !sos && busy;
  wire [IDX_W-1:0] last = long_q ? IDX_W'(MAXC-1) : IDX_W'(MAXC/2-1);
  wire signed [ACC_W-1:0] smp_x = {{(ACC_W-SMP_W){chip_smp[SMP_W-1]}}, chip_smp};

  function automatic logic ref_bit(input logic lg, input logic [3:0] s, input logic [3:0] i);
    logic [3:0] j;
    logic [2:0] k;
    j = i - {s[2:0], 1'b0};
    k = i[2:0] - s[2:0];
    if (lg) ref_bit = ROOT_L[~j] ^ (s[3] & j[0]);
    else    ref_bit = ROOT_S[~k] ^ (s[3] & k[0]);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      long_q <= 1'b0;
      done_q <= 1'b0;
      for (int s = 0; s < NSYM; s++) acc[s] <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        cnt    <= '0;
        long_q <= len16;
        for (int s = 0; s < NSYM; s++) acc[s] <= '0;
      end else if (take) begin
        for (int s = 0; s < NSYM; s++)
          acc[s] <= acc[s] + (ref_bit(long_q, 4'(s), cnt) ? -smp_x : smp_x);
        cnt <= cnt + 1'b1;
        if (cnt == last) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  logic [SYM_W-1:0] best_i;
  logic signed [ACC_W-1:0] best_v;

  always_comb begin
    best_i = '0;
    best_v = acc[0];
    for (int s = 1; s < NSYM; s++)
      if (acc[s] > best_v) begin
        best_v = acc[s];
        best_i = SYM_W'(s);
      end
  end

  assign sym_vld  = done_q;
  assign sym_out  = best_i;
  assign sym_peak = best_v;

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst) sym_vld |=> !sym_vld); // R5
  AST_AFTER_CHIP: assert property (@(posedge clk) disable iff (rst) sym_vld |-> $past(chip_vld && !sos)); // R5
  AST_START_QUIET: assert property (@(posedge clk) disable iff (rst) start |=> !sym_vld); // R8
  AST_GUARD_DROP: assert property (@(posedge clk) disable iff (rst) start |=> (sym_peak == 0 && sym_out == 0)); // R4
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst) !chip_vld |=> ($stable(sym_peak) && $stable(sym_out))); // R6
endmodule

// File: tb/cyc_despreader_test.sv
module cyc_despreader_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst, chip_vld, sos, len16;
  logic signed [7:0] chip_smp;
  logic sym_vld;
  logic [3:0] sym_out;
  logic signed [12:0] sym_peak;

  int total = 0, bad = 0;
  int unsigned seed = 32'h1234_5678;

  // {len16, symbol, amplitude}
  localparam logic [12:0] VEC [12] = '{
    {1'b0, 4'd0, 8'd100}, {1'b0, 4'd1, 8'd50}, {1'b0, 4'd7, 8'd127},
    {1'b0, 4'd8, 8'd90},  {1'b0, 4'd13, 8'd64}, {1'b0, 4'd15, 8'd20},
    {1'b1, 4'd0, 8'd100}, {1'b1, 4'd3, 8'd127}, {1'b1, 4'd6, 8'd33},
    {1'b1, 4'd9, 8'd77},  {1'b1, 4'd12, 8'd110}, {1'b1, 4'd15, 8'd5}
  };

  cyc_despreader uut (
    .clk(clk), .rst(rst), .chip_vld(chip_vld), .sos(sos), .len16(len16),
    .chip_smp(chip_smp), .sym_vld(sym_vld), .sym_out(sym_out), .sym_peak(sym_peak)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_seq(input logic lg, input logic [3:0] s);
    int n = lg ? 16 : 8;
    logic [15:0] root = lg ? 16'h2F53 : 16'h005C;
    logic [15:0] b = '0;
    for (int i = 0; i < n; i++) b[i] = root[n-1-i] ^ (s[3] && (i % 2 == 1));
    for (int r = 0; r < (lg ? 2 : 1) * int'(s[2:0]); r++) begin
      logic t;
      t = b[n-1];
      for (int i = n - 1; i > 0; i--) b[i] = b[i-1];
      b[0] = t;
    end
    return b;
  endfunction

  task automatic drive(input logic st, input int v);
    @(negedge clk);
    sos = st; chip_vld = 1'b1; chip_smp = 8'(v);
  endtask

  task automatic idle();
    @(negedge clk);
    sos = 1'b0; chip_vld = 1'b0; chip_smp = 8'sh7F;
  endtask

  // sends one symbol; returns bench-computed decision over the sent samples
  task automatic send(input logic lg, input logic [3:0] s, input int amp, input int noise,
                      input int guard, input bit gaps, output int pk, output int sy);
    int n = lg ? 16 : 8;
    int smp [16];
    logic [15:0] seq = mk_seq(lg, s);
    @(negedge clk);
    len16 = lg;
    drive(1'b1, guard);
    for (int i = 0; i < n; i++) begin
      int v = seq[i] ? -amp : amp;
      if (noise > 0) begin
        seed = seed * 1103515245 + 12345;
        v += int'((seed >> 16) % (2 * noise + 1)) - noise;
      end
      if (v > 127) v = 127;
      if (v < -128) v = -128;
      smp[i] = v;
      if (gaps) idle();
      drive(1'b0, v);
    end
    sy = 0; pk = -100000;
    for (int t = 0; t < 16; t++) begin
      logic [15:0] rs = mk_seq(lg, 4'(t));
      int c = 0;
      for (int i = 0; i < n; i++) c += rs[i] ? -smp[i] : smp[i];
      if (c > pk) begin pk = c; sy = t; end
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int pk, sy, n;
    rst = 1'b1; chip_vld = 1'b0; sos = 1'b0; len16 = 1'b0; chip_smp = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sym_vld == 1'b0, "R1 vld", int'(sym_vld), 0);
    chk(sym_out == 4'd0, "R1 sym", int'(sym_out), 0);
    chk(sym_peak == 0, "R1 peak", int'(sym_peak), 0);

    // R2 R3: table of ideal symbols, guard chip alternating extremes (R4)
    foreach (VEC[k]) begin
      logic lg = VEC[k][12];
      logic [3:0] s = VEC[k][11:8];
      int a = int'(VEC[k][7:0]);
      n = lg ? 16 : 8;
      send(lg, s, a, 0, (k % 2) ? 127 : -128, 1'b0, pk, sy);
      idle();
      chk(sym_vld == 1'b1, lg ? "R3 vld" : "R2 vld", int'(sym_vld), 1);
      chk(sym_out == s, lg ? "R3 sym" : "R2 sym", int'(sym_out), int'(s));
      chk(int'(sym_peak) == n * a, "R4 peak guard dropped", int'(sym_peak), n * a);
      idle();
      chk(sym_vld == 1'b0, "R5 single pulse", int'(sym_vld), 0);
    end

    // R6: gaps with garbage samples between chips
    send(1'b1, 4'd11, 60, 0, 0, 1'b1, pk, sy);
    idle();
    chk(sym_vld == 1'b1 && sym_out == 4'd11, "R6 gaps sym", int'(sym_out), 11);
    chk(int'(sym_peak) == 960, "R6 gaps peak", int'(sym_peak), 960);
    // R6: stray chips after completion ignored
    for (int i = 0; i < 10; i++) drive(1'b0, (i % 2) ? 100 : -100);
    idle();
    chk(sym_vld == 1'b0, "R6 stray no vld", int'(sym_vld), 0);
    chk(sym_out == 4'd11 && int'(sym_peak) == 960, "R6 stray peak", int'(sym_peak), 960);

    // R7: all-zero samples tie every symbol
    send(1'b0, 4'd5, 0, 0, 50, 1'b0, pk, sy);
    idle();
    chk(sym_vld == 1'b1 && sym_out == 4'd0, "R7 tie lowest", int'(sym_out), 0);
    chk(sym_peak == 0, "R7 tie peak", int'(sym_peak), 0);

    // R8: restart in the middle of a long symbol, new one short
    @(negedge clk); len16 = 1'b1;
    drive(1'b1, 10);
    for (int i = 0; i < 5; i++) drive(1'b0, 90);
    idle();
    chk(sym_vld == 1'b0, "R8 no vld before restart", int'(sym_vld), 0);
    send(1'b0, 4'd6, 80, 0, -70, 1'b0, pk, sy);
    idle();
    chk(sym_vld == 1'b1 && sym_out == 4'd6, "R8 restarted sym", int'(sym_out), 6);
    chk(int'(sym_peak) == 640, "R8 restarted peak", int'(sym_peak), 640);
    idle();
    chk(sym_vld == 1'b0, "R8 single report", int'(sym_vld), 0);

    // R9: noisy symbols against bench correlation
    for (int k = 0; k < 16; k++) begin
      logic lg = k[0];
      send(lg, 4'(k * 7), 40, 45, 0, 1'b0, pk, sy);
      idle();
      chk(sym_vld == 1'b1 && int'(sym_out) == sy, "R9 noisy sym", int'(sym_out), sy);
      chk(int'(sym_peak) == pk, "R9 noisy peak", int'(sym_peak), pk);
    end

    // R9: negative-going samples: strong inverse of symbol 2 (long)
    send(1'b1, 4'd2, -120, 0, 0, 1'b0, pk, sy);
    idle();
    chk(int'(sym_out) == sy, "R9 inverted sym", int'(sym_out), sy);
    chk(int'(sym_peak) == pk, "R9 inverted peak", int'(sym_peak), pk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule